// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Register Unit

This block keeps the two threshold values that a FIFO uses to raise its almost-empty and almost-full flags. Both thresholds take a default when the master reset is applied. The level of the load pin during that reset chooses the default and also fixes the loading method. Low selects parallel loading, with both thresholds set to 127. High selects serial loading, with both thresholds set to 1023.

After reset, software can rewrite the thresholds under the write clock. In parallel mode it writes whole data words. In serial mode it shifts in one bit at a time. Under the read clock it can read the thresholds back as data words. The block compares the FIFO word count supplied by the storage logic with both thresholds, combinationally. The almost-empty threshold is measured up from an empty FIFO, and the almost-full threshold is measured down from a full one. A partial reset restarts both sequencers and keeps the thresholds and the loading method.

Top module: `ofs_thresholds`

## Requirements
- R1: Master reset with `ld` low selects parallel mode and sets both thresholds to 127. It also clears `q` to 0 and restarts both sequencers.
- R2: Master reset with `ld` high selects serial mode and sets both thresholds to 1023.
- R3: In parallel mode, each rising `wclk` edge with `wen` and `ld` both high stores `d` into the next word. With W=9 and a 15-bit threshold, the order is: empty bits 8:0, then empty bits 14:9 (taken from `d[5:0]`, with `d[8:6]` dropped), then the same two words for the full threshold. After that the order wraps to the start.
- R4: In serial mode, each rising `wclk` edge with `sen` and `ld` both high stores `si` into the next bit. The order is the empty threshold from bit 0 to bit 14, then the full threshold from bit 0 to bit 14, and then it wraps.
- R5: The method not selected at reset has no effect. Write edges where `ld` is low also have no effect.
- R6: Each rising `rclk` edge with `ren` and `ld` both high loads `q` with the next readback word. Readback uses the same word order as R3, with unused upper bits set to 0. Its sequencer is independent of the load sequencer and wraps after four words. In all other cycles `q` holds its value.
- R7: `almost_empty` is high exactly when `level` is less than or equal to the empty threshold.
- R8: `almost_full` is high exactly when `DEPTH - level` is less than or equal to the full threshold.
- R9: Partial reset restarts the load and readback sequencers and clears `q`. It keeps both thresholds and the loading method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, seen on both clocks |
| prst | input | 1 | Partial reset, active high, seen on both clocks |
| ld | input | 1 | Load pin: selects the mode during reset, enables access afterwards |
| sen | input | 1 | Serial load enable |
| si | input | 1 | Serial data bit |
| wen | input | 1 | Parallel write enable |
| d | input | W | Parallel write data |
| ren | input | 1 | Readback enable |
| q | output | W | Readback data |
| level | input | CNT_W | FIFO word count |
| almost_empty | output | 1 | Word count at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |

## Verification
Word counts are driven exactly at each threshold and one step either side of it, and also at 0 and DEPTH. These values show whether each comparison is inclusive, and whether the full flag measures free space rather than occupancy. Random words that set bits 8:6 of the upper-part write show that the truncated bits are dropped. Random serial bit streams show bit order and the boundary between the two thresholds. Read requests mixed in at random between loads, with and without `ld`, show that the readback order is independent of the load order. Writes that use the method not selected at reset are also mixed in, together with a partial reset part way through a load. These show that a sequencer restart does not disturb the stored thresholds.

// File: rtl/ofs_thresholds.sv
module ofs_thresholds #(
  parameter int W       = 9,
  parameter int OFS_W   = 15,
  parameter int DEPTH   = 32768,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrst,
  input  logic             prst,
  input  logic             ld,
  input  logic             sen,
  input  logic             si,
  input  logic             wen,
  input  logic [W-1:0]     d,
  input  logic             ren,
  output logic [W-1:0]     q,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  output logic             almost_empty,
  output logic             almost_full
);
  localparam int NW   = (OFS_W + W - 1) / W;
  localparam int IW   = $clog2(2 * OFS_W);
  localparam int RW   = $clog2(2 * NW);

  logic             ser_mode;
  logic [OFS_W-1:0] ofs_e, ofs_f;
  logic [IW-1:0]    lidx;
  logic [RW-1:0]    ridx;
  logic [W-1:0]     rd_word;

  wire do_par = !ser_mode && wen && ld;
  wire do_ser =  ser_mode && sen && ld;
  wire [IW-1:0] lim = ser_mode ? IW'(2 * OFS_W - 1) : IW'(2 * NW - 1);

  always_ff @(posedge wclk) begin
    if (mrst) begin
      ser_mode <= ld;
      ofs_e    <= ld ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR);
      ofs_f    <= ld ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR);
      lidx     <= '0;
    end else if (prst) begin
      lidx <= '0;
    end else if (do_par || do_ser) begin
      lidx <= (lidx == lim) ? '0 : lidx + 1'b1;
      for (int b = 0; b < OFS_W; b++) begin
        if (do_ser && int'(lidx) == b)          ofs_e[b] <= si;
        if (do_ser && int'(lidx) == b + OFS_W)  ofs_f[b] <= si;
        if (do_par && int'(lidx) == b / W)      ofs_e[b] <= d[b % W];
        if (do_par && int'(lidx) == NW + b / W) ofs_f[b] <= d[b % W];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int j = 0; j < W; j++)
      for (int b = 0; b < OFS_W; b++)
        if (b == (int'(ridx) % NW) * W + j)
          rd_word[j] = (int'(ridx) >= NW) ? ofs_f[b] : ofs_e[b];
  end

  always_ff @(posedge rclk) begin
    if (mrst || prst) begin
      ridx <= '0;
      q    <= '0;
    end else if (ren && ld) begin
      q    <= rd_word;
      ridx <= (int'(ridx) == 2 * NW - 1) ? '0 : ridx + 1'b1;
    end
  end

  assign almost_empty = int'(level) <= int'(ofs_e);
  assign almost_full  = (DEPTH - int'(level)) <= int'(ofs_f);

  // R2
  default_load_chk: assert property (@(posedge wclk) disable iff (prst)
    mrst |=> (ofs_e == ($past(ld) ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR))) &&
             (ofs_f == ($past(ld) ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR))));
  // R5
  no_stray_write_chk: assert property (@(posedge wclk) disable iff (mrst)
    !ld |=> $stable(ofs_e) && $stable(ofs_f));
  // R9
  mode_keep_chk: assert property (@(posedge wclk) disable iff (mrst)
    !mrst |=> $stable(ser_mode));
  // R3
  par_wrap_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
    (do_par && int'(lidx) == 2 * NW - 1) |=> lidx == '0);
  // R6
  q_hold_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
    !(ren && ld) |=> $stable(q));
endmodule

// File: tb/ofs_thresholds_test.sv
module ofs_thresholds_test;
  localparam int W = 9, OFS_W = 15, DEPTH = 32768, NW = 2, CW = 16;

  logic wclk = 0, rclk = 0;
  logic mrst = 0, prst = 0, ld = 0, sen = 0, si = 0, wen = 0, ren = 0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q;
  logic [CW-1:0] level = '0;
  logic almost_empty, almost_full;

  ofs_thresholds uut (.wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .ld(ld),
    .sen(sen), .si(si), .wen(wen), .d(d), .ren(ren), .q(q), .level(level),
    .almost_empty(almost_empty), .almost_full(almost_full));

  always #5 wclk = ~wclk;
  initial begin #3; forever #5 rclk = ~rclk; end

  int total = 0, fails = 0;
  bit [OFS_W-1:0] me, mf;
  bit mmode;
  int mlidx, mridx;
  bit [W-1:0] mq;

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic bit [W-1:0] exp_word(int idx);
    bit [W-1:0] w = '0;
    for (int j = 0; j < W; j++) begin
      int b = (idx % NW) * W + j;
      if (b < OFS_W) w[j] = (idx >= NW) ? mf[b] : me[b];
    end
    return w;
  endfunction

  task automatic do_mrst(bit l);
    @(negedge wclk); mrst = 1; ld = l; wen = 0; sen = 0; ren = 0;
    repeat (2) @(negedge wclk);
    mrst = 0; ld = 0;
    mmode = l; me = l ? 15'd1023 : 15'd127; mf = me;
    mlidx = 0; mridx = 0; mq = '0;
  endtask

  task automatic do_prst();
    @(negedge wclk); prst = 1;
    repeat (2) @(negedge wclk);
    prst = 0; mlidx = 0; mridx = 0; mq = '0;
  endtask

  task automatic wr(bit l, bit w, bit s, bit sb, bit [W-1:0] dv);
    @(negedge wclk); ld = l; wen = w; sen = s; si = sb; d = dv;
    @(posedge wclk);
    if (l && w && !mmode) begin
      for (int b = 0; b < OFS_W; b++) begin
        if (mlidx == b / W) me[b] = dv[b % W];
        if (mlidx == NW + b / W) mf[b] = dv[b % W];
      end
      mlidx = (mlidx == 2 * NW - 1) ? 0 : mlidx + 1;
    end else if (l && s && mmode) begin
      if (mlidx < OFS_W) me[mlidx] = sb; else mf[mlidx - OFS_W] = sb;
      mlidx = (mlidx == 2 * OFS_W - 1) ? 0 : mlidx + 1;
    end
    @(negedge wclk); ld = 0; wen = 0; sen = 0;
  endtask

  task automatic rd(string r, bit l, bit e);
    @(negedge rclk); ld = l; ren = e;
    @(posedge rclk);
    if (l && e) begin
      mq = exp_word(mridx);
      mridx = (mridx == 2 * NW - 1) ? 0 : mridx + 1;
    end
    @(negedge rclk); ld = 0; ren = 0;
    chk(r, q, mq);
  endtask

  task automatic flags(int lv);
    level = CW'(lv); #1;
    chk("R7 almost_empty", almost_empty, lv <= int'(me));
    chk("R8 almost_full", almost_full, (DEPTH - lv) <= int'(mf));
  endtask

  task automatic edges();
    flags(me); flags(me + 1); if (me > 0) flags(me - 1);
    flags(DEPTH - mf); flags(DEPTH - mf - 1);
    if (mf > 0) flags(DEPTH - mf + 1);
    flags(0); flags(DEPTH);
  endtask

  task automatic rand_phase(int n);
    for (int i = 0; i < n; i++) begin
      case ($urandom % 6)
        0: wr(1, 1, 0, 0, W'($urandom));
        1: wr(1, 0, 1, 1'($urandom), '0);
        2: rd("R6 readback", 1, 1);
        3: rd("R6 hold without ld", 0, 1);
        4: flags(int'($urandom % (DEPTH + 1)));
        default: begin wr(0, 1, 1, 1'($urandom), W'($urandom)); edges(); end
      endcase
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_mrst(0);
    @(negedge rclk); chk("R1 q after reset", q, 0);
    flags(127); flags(128); flags(DEPTH - 127); flags(DEPTH - 128);
    chk("R1 default empty", int'(me), 127);
    for (int i = 0; i < 5; i++) rd("R1 R6 default readback", 1, 1);
    // R3 directed, upper bits of high part dropped
    wr(1, 1, 0, 0, 9'h1A5); wr(1, 1, 0, 0, 9'h1C3);
    wr(1, 1, 0, 0, 9'h010); wr(1, 1, 0, 0, 9'h000);
    chk("R3 empty value", int'(me), 'h3 * 512 + 'h1A5);
    edges();
    wr(1, 1, 0, 0, 9'h005); chk("R3 wrap to empty", int'(me), 'h3 * 512 + 5);
    edges();
    // R5 serial and ld-less writes ignored in parallel mode
    wr(1, 0, 1, 1, '0); wr(0, 1, 0, 0, 9'h1FF); edges();
    for (int i = 0; i < 4; i++) rd("R5 R6 readback", 1, 1);
    rand_phase(250);
    // R9 partial reset mid-load
    wr(1, 1, 0, 0, 9'h0AA);
    do_prst();
    edges();
    rd("R9 readback restart", 1, 1);
    wr(1, 1, 0, 0, 9'h077); edges();
    chk("R9 load restart", int'(me[8:0]), 'h77);
    // serial mode
    do_mrst(1);
    flags(1023); flags(1024); flags(DEPTH - 1023); flags(DEPTH - 1024);
    for (int i = 0; i < 4; i++) rd("R2 default readback", 1, 1);
    for (int i = 0; i < 2 * OFS_W; i++) wr(1, 0, 1, 1'(i % 3 == 0), '0);
    chk("R4 empty bits", int'(me), int'(mf));
    edges();
    wr(1, 1, 0, 0, 9'h1FF); edges();
    rand_phase(250);
    do_prst();
    chk("R9 mode kept", int'(mmode), 1);
    wr(1, 0, 1, 0, '0); edges();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule